// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This block resolves the single-word conditional jump format of a 16-bit processor. Each cycle it looks at the fetched instruction word, the program counter that already points past that word, and the four status flags. It reports whether the word is a jump, whether the jump is taken and which program counter comes next. The branch distance is a 10-bit signed count of words inside the instruction. It is doubled into bytes and added to the advanced program counter, wrapping modulo 2^16. A word that is not a jump, or a jump whose condition fails, passes the incoming program counter through unchanged.

The same block holds a compare-flag generator that forms destination minus source and produces the N, Z, C and V flags a compare would leave. It is used to build flag sets for testing the condition logic. All outputs are registered, so a result appears one clock after its inputs.

Top module: `jcu_top`

## Requirements
- R1: While rst_ni is low, is_jump_o, taken_o, pc_o and cmp_flags_o are all zero.
- R2: A word is a jump when instr_i[15:13] == 3'b001; for any other word is_jump_o and taken_o are 0 and pc_o equals pc_next_i.
- R3: The condition field instr_i[12:10] selects: 0 Z==0, 1 Z==1, 2 C==0, 3 C==1, 4 N==1, 5 (N xor V)==0 (signed greater-or-equal), 6 (N xor V)==1 (signed less), 7 always.
- R4: A taken jump gives pc_o = pc_next_i + 2 * sign_extend(instr_i[9:0]) modulo 2^16; offset 0x3FF (-1) gives pc_next_i - 2 (the jump itself), 0x200 gives -1024 bytes, 0x1FF gives +1022 bytes.
- R5: A jump whose condition fails gives taken_o = 0 and pc_o = pc_next_i.
- R6: flags_i carries N at bit 3, Z at bit 2, C at bit 1, V at bit 0; no other status bit (such as an interrupt enable) is an input, so only these four affect the decision.
- R7: cmp_flags_o (same bit order as flags_i) holds N = bit 15 of cmp_dst_i - cmp_src_i and Z = 1 when that difference is zero.
- R8: In cmp_flags_o, C = 1 when no borrow occurs (cmp_dst_i >= cmp_src_i unsigned) and V = 1 on signed overflow of the subtraction; 0xF000 - 0x0FFF gives N=1 Z=0 C=1 V=0.
- R9: Every output reflects the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 16 | Fetched instruction word |
| pc_next_i | input | 16 | Program counter already advanced past the word |
| flags_i | input | 4 | Status flags {N, Z, C, V} |
| cmp_dst_i | input | 16 | Compare destination operand |
| cmp_src_i | input | 16 | Compare source operand |
| is_jump_o | output | 1 | Word decodes as a conditional jump |
| taken_o | output | 1 | Jump is taken |
| pc_o | output | 16 | Next program counter |
| cmp_flags_o | output | 4 | Compare flags {N, Z, C, V} |

## Verification
A mis-decoded condition or a swapped flag bit shows as a wrong taken_o one cycle after the offending word, and when the jump is taken pc_o moves by the offset instead of holding the incoming value. A sign-extension or scaling error in the target adder shows in pc_o one cycle later on the first jump with a negative or large offset, so the bench pairs random words with directed offsets at -1, -512 and +511 words and wrap-around program counters. Compare flag errors appear in cmp_flags_o on the cycle after the operands, with borrow and signed-overflow edges driven directly.

// File: rtl/jcu_pkg.sv
package jcu_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned OFF_W  = 10;
  localparam int unsigned COND_W = 3;
  localparam logic [2:0]  JMP_OP = 3'b001;

  typedef enum logic [COND_W-1:0] {
    COND_NZ  = 3'd0,
    COND_Z   = 3'd1,
    COND_NC  = 3'd2,
    COND_C   = 3'd3,
    COND_NEG = 3'd4,
    COND_GE  = 3'd5,
    COND_LT  = 3'd6,
    COND_ALW = 3'd7
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/jcu_decode.sv
module jcu_decode
  import jcu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OFF_W
) (
  input  logic [DW-1:0] instr_i,
  output logic          is_jump_o,
  output cond_e         cond_o,
  output logic [OW-1:0] off_o
);
  localparam int unsigned OP_LSB = OW + COND_W;

  assign is_jump_o = (instr_i[DW-1:OP_LSB] == JMP_OP);
  assign cond_o    = cond_e'(instr_i[OP_LSB-1:OW]);
  assign off_o     = instr_i[OW-1:0];
endmodule

// File: rtl/jcu_cond_eval.sv
module jcu_cond_eval
  import jcu_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   pass_o
);
  logic lt;
  assign lt = flags_i.n ^ flags_i.v;

  always_comb begin
    unique case (cond_i)
      COND_NZ:  pass_o = ~flags_i.z;
      COND_Z:   pass_o = flags_i.z;
      COND_NC:  pass_o = ~flags_i.c;
      COND_C:   pass_o = flags_i.c;
      COND_NEG: pass_o = flags_i.n;
      COND_GE:  pass_o = ~lt;
      COND_LT:  pass_o = lt;
      default:  pass_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/jcu_target.sv
module jcu_target #(
  parameter int unsigned DW = 16,
  parameter int unsigned OW = 10
) (
  input  logic [DW-1:0] pc_next_i,
  input  logic [OW-1:0] off_i,
  output logic [DW-1:0] target_o
);
  localparam int unsigned EXT_W = DW - OW - 1;

  logic [DW-1:0] byte_off;
  // word offset -> byte offset, sign extended
  assign byte_off = {{EXT_W{off_i[OW-1]}}, off_i, 1'b0};
  assign target_o = pc_next_i + byte_off;
endmodule

// File: rtl/jcu_cmp_flags.sv
module jcu_cmp_flags
  import jcu_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  output flags_t        flags_o
);
  logic [DW:0] diff;
  // dst + ~src + 1; carry out set means no borrow
  assign diff = {1'b0, dst_i} + {1'b0, ~src_i} + {{DW{1'b0}}, 1'b1};

  assign flags_o.n = diff[DW-1];
  assign flags_o.z = (diff[DW-1:0] == '0);
  assign flags_o.c = diff[DW];
  assign flags_o.v = (dst_i[DW-1] ^ src_i[DW-1]) & (diff[DW-1] ^ dst_i[DW-1]);
endmodule

// File: rtl/jcu_top.sv
module jcu_top
  import jcu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] pc_next_i,
  input  logic [3:0]        flags_i,
  input  logic [DATA_W-1:0] cmp_dst_i,
  input  logic [DATA_W-1:0] cmp_src_i,
  output logic              is_jump_o,
  output logic              taken_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [3:0]        cmp_flags_o
);
  logic              is_jump_c, pass_c, taken_c;
  cond_e             cond_c;
  logic [OFF_W-1:0]  off_c;
  logic [DATA_W-1:0] target_c, pc_c;
  flags_t            cmp_c;

  jcu_decode #(.DW(DATA_W), .OW(OFF_W)) u_dec (
    .instr_i  (instr_i),
    .is_jump_o(is_jump_c),
    .cond_o   (cond_c),
    .off_o    (off_c)
  );

  jcu_cond_eval u_cond (
    .cond_i (cond_c),
    .flags_i(flags_t'(flags_i)),
    .pass_o (pass_c)
  );

  jcu_target #(.DW(DATA_W), .OW(OFF_W)) u_tgt (
    .pc_next_i(pc_next_i),
    .off_i    (off_c),
    .target_o (target_c)
  );

  jcu_cmp_flags #(.DW(DATA_W)) u_cmp (
    .dst_i  (cmp_dst_i),
    .src_i  (cmp_src_i),
    .flags_o(cmp_c)
  );

  assign taken_c = is_jump_c & pass_c;
  assign pc_c    = taken_c ? target_c : pc_next_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_jump_o   <= 1'b0;
      taken_o     <= 1'b0;
      pc_o        <= '0;
      cmp_flags_o <= '0;
    end else begin
      is_jump_o   <= is_jump_c;
      taken_o     <= taken_c;
      pc_o        <= pc_c;
      cmp_flags_o <= cmp_c;
    end
  end

  AST_NON_JUMP_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:13] != 3'b001) |=> (!taken_o && pc_o == $past(pc_next_i))); // R2
  AST_ALWAYS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:10] == 6'b001111) |=> taken_o); // R3
  AST_EQ_NEEDS_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:10] == 6'b001001 && !flags_i[2]) |=> (!taken_o && pc_o == $past(pc_next_i))); // R5
  AST_SELF_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 16'h3FFF) |=> (pc_o == $past(pc_next_i) - 16'd2)); // R4
  AST_CMP_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_dst_i == cmp_src_i) |=> (cmp_flags_o[2] && cmp_flags_o[1] && !cmp_flags_o[0])); // R8
  AST_TAKEN_IS_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> is_jump_o); // R2
endmodule

// File: tb/jcu_top_test.sv
`timescale 1ns/1ps
module jcu_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0, pc_next_i = '0, cmp_dst_i = '0, cmp_src_i = '0;
  logic [3:0]  flags_i = '0;
  logic        is_jump_o, taken_o;
  logic [15:0] pc_o;
  logic [3:0]  cmp_flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  jcu_top uut (.*);

  function automatic bit f_is_jump(input logic [15:0] w);
    return w[15:13] == 3'b001;
  endfunction

  function automatic bit f_pass(input logic [2:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !cy;
      3'd3: return cy;
      3'd4: return n;
      3'd5: return (n ^ v) == 1'b0;
      3'd6: return (n ^ v) == 1'b1;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] f_pc(input logic [15:0] w, input logic [15:0] pc, input logic [3:0] f);
    int off;
    if (!(f_is_jump(w) && f_pass(w[12:10], f))) return pc;
    off = w[9] ? int'(w[9:0]) - 1024 : int'(w[9:0]);
    return 16'((int'(pc) + 2 * off) & 16'hFFFF);
  endfunction

  function automatic logic [3:0] f_cmp(input logic [15:0] d, input logic [15:0] s);
    int sd = $signed(d), ss = $signed(s), r = sd - ss;
    logic [15:0] res = d - s;
    return {res[15], res == 16'h0, d >= s, (r > 32767) || (r < -32768)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [15:0] pc, input logic [3:0] f,
                       input logic [15:0] d, input logic [15:0] s, input string tag);
    @(negedge clk_i);
    instr_i = w; pc_next_i = pc; flags_i = f; cmp_dst_i = d; cmp_src_i = s;
    @(negedge clk_i);  // one register stage: result visible after next posedge (R9)
    chk({tag, " is_jump R2"}, 16'(is_jump_o), 16'(f_is_jump(w)));
    chk({tag, " taken R3"}, 16'(taken_o), 16'(f_is_jump(w) && f_pass(w[12:10], f)));
    chk({tag, " pc R4"}, pc_o, f_pc(w, pc, f));
    chk({tag, " cmp R7"}, 16'(cmp_flags_o), 16'(f_cmp(d, s)));
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    instr_i = 16'h3FFF; pc_next_i = 16'h1234; flags_i = 4'hF; cmp_dst_i = 16'h5; cmp_src_i = 16'h3;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 is_jump", 16'(is_jump_o), 16'h0);
    chk("R1 taken", 16'(taken_o), 16'h0);
    chk("R1 pc", pc_o, 16'h0);
    chk("R1 cmp", 16'(cmp_flags_o), 16'h0);
    rst_ni = 1'b1;

    // R4 self loop, -512 and +511 words, wrap
    apply(16'h3FFF, 16'h0102, 4'h0, 16'h0, 16'h0, "R4 self");
    chk("R4 self explicit", pc_o, 16'h0100);
    apply(16'h3E00, 16'h0400, 4'h0, 16'h0, 16'h0, "R4 min");
    chk("R4 min explicit", pc_o, 16'h0000);
    apply(16'h3DFF, 16'h0400, 4'h0, 16'h0, 16'h0, "R4 max");
    chk("R4 max explicit", pc_o, 16'h07FE);
    apply(16'h3C10, 16'hFFF0, 4'h0, 16'h0, 16'h0, "R4 wrap");
    chk("R4 wrap explicit", pc_o, 16'h0010);
    // R8 compare example, then GE not taken and HS taken with those flags
    apply(16'h0000, 16'h2000, 4'h0, 16'hF000, 16'h0FFF, "R8 example");
    chk("R8 example flags", 16'(cmp_flags_o), 16'h000A);
    apply(16'h3405, 16'h2000, 4'hA, 16'h0, 16'h0, "R3 ge");
    chk("R5 ge not taken", pc_o, 16'h2000);
    apply(16'h2C05, 16'h2000, 4'hA, 16'h0, 16'h0, "R6 hs");
    chk("R6 carry taken", 16'(taken_o), 16'h1);
    // R7 equal operands, R8 signed overflow
    apply(16'h0000, 16'h0, 4'h0, 16'h7FFF, 16'h7FFF, "R7 eq");
    chk("R7 zero flag", 16'(cmp_flags_o), 16'h0006);
    apply(16'h0000, 16'h0, 4'h0, 16'h7FFF, 16'hFFFF, "R8 ovf");
    chk("R8 overflow", 16'(cmp_flags_o), 16'h0009);
    // R2 non-jump with near opcode, R5 each condition with all flag sets
    apply(16'h5FFF, 16'hABCD, 4'hF, 16'h1, 16'h2, "R2 nonjump");
    chk("R2 passthrough", pc_o, 16'hABCD);
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++)
        apply({3'b001, 3'(c), 10'h005}, 16'h3000, 4'(f), 16'(f), 16'(c), "R5 table");
    // random mix
    for (int k = 0; k < 1500; k++) begin
      logic [15:0] w = 16'($urandom);
      if (k % 2 == 0) w[15:13] = 3'b001;
      apply(w, 16'($urandom), 4'($urandom), 16'($urandom), 16'($urandom), "R9 random");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule